// File: doc/BRIEF.md
# Per-Thread Interrupt Priority Presenter

This block holds the interrupt presentation state of one processor thread across eight priority levels, where a smaller number means a more favoured level. Incoming notifications and software set-pending writes each mark one level in a pending buffer. The buffer yields the most favoured pending priority, which is compared with the thread's current priority. When the pending level is strictly more favoured, an exception flag is set and the level-sensitive interrupt line rises.

Software takes the interrupt with an acknowledge strobe. In the same cycle the block returns a 16-bit response that carries the status byte from before the acknowledge and the current priority that results from it. At the clock edge the pending priority becomes the current priority, that level leaves the pending buffer, and the exception flag drops. Software can also write the current priority at any time, which starts a new comparison.

Top module: `irq_prio_ctx`

## Requirements
- R1: After reset `pend_prio` reads 0xFF, `cur_prio` reads 0, and `irq_out` is low, so no level can raise an interrupt until software writes the current priority.
- R2: A notification of priority p (0..7) marks level p as pending. From the next cycle, `pend_prio` reads the smallest pending level.
- R3: A notification or set-pending write with a priority above 7 marks no level and leaves `pend_prio` unchanged.
- R4: After a cycle with a notification, set-pending write or current-priority write, if the updated `pend_prio` is strictly below the updated `cur_prio`, the exception flag (status bit 7) and `irq_out` are high from the next cycle.
- R5: When the updated pending priority is equal to or above the current priority, no exception is raised.
- R6: A current-priority write loads `cur_wdata` into `cur_prio` at the next edge. The full 8-bit value is kept.
- R7: An acknowledge with the exception flag set moves `pend_prio` into `cur_prio`, removes that level from the pending buffer, and clears the exception flag and `irq_out`.
- R8: While `ack` is high, `ack_resp[15:8]` holds the status byte (bit 7 is the exception flag, the other bits are zero) and `ack_resp[7:0]` holds the current priority the acknowledge leaves. `ack_resp` is zero when `ack` is low.
- R9: An acknowledge with the exception flag clear leaves `cur_prio` and `pend_prio` unchanged.
- R10: A set-pending write behaves like a notification. When both arrive in the same cycle, both levels are merged.
- R11: When a notification and an acknowledge arrive in the same cycle, the acknowledge takes effect first. The new level is then merged and compared with the priority the acknowledge produced, so no notification is lost.
- R12: When a current-priority write and an acknowledge arrive in the same cycle, the written value ends up in `cur_prio`, and the acknowledge still consumes its pending level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid | input | 1 | Notification strobe |
| ntf_prio | input | 8 | Priority of the notification |
| cur_wr | input | 1 | Current-priority write strobe |
| cur_wdata | input | 8 | New current priority |
| pend_wr | input | 1 | Software set-pending write strobe |
| pend_wdata | input | 8 | Priority to mark pending |
| ack | input | 1 | Acknowledge strobe |
| ack_resp | output | 16 | Status before the acknowledge and resulting current priority |
| irq_out | output | 1 | Level interrupt to the thread |
| cur_prio | output | 8 | Current priority |
| pend_prio | output | 8 | Most favoured pending priority, 0xFF when none |

## Verification
The assertions assume that every strobe is a single-cycle, synchronous pulse that is clean at the clock edge. They assume nothing else about how the strobes combine, so any mix of them in one cycle is legal and the properties must hold under it. Priorities are arbitrary 8-bit values. The stimulus uses directed sequences and then a long random phase that draws priorities from 0 to 9, with an occasional 0xFF current priority. It fires every strobe independently, so simultaneous notify, write and acknowledge cycles occur often.

// File: rtl/irq_prio_ctx.sv
module irq_prio_ctx #(
  parameter int unsigned NLVL = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ntf_valid,
  input  logic [7:0]  ntf_prio,
  input  logic        cur_wr,
  input  logic [7:0]  cur_wdata,
  input  logic        pend_wr,
  input  logic [7:0]  pend_wdata,
  input  logic        ack,
  output logic [15:0] ack_resp,
  output logic        irq_out,
  output logic [7:0]  cur_prio,
  output logic [7:0]  pend_prio
);
  localparam logic [7:0] NONE = 8'hFF;

  logic [NLVL-1:0] pbuf, pbuf_a, pbuf_n;
  logic [7:0]      cppr, cppr_a, cppr_n, pipr, pipr_n;
  logic            exc, exc_n, take, event_in;

  function automatic logic [NLVL-1:0] lvl_bit(input logic [7:0] p);
    lvl_bit = '0;
    for (int i = 0; i < NLVL; i++)
      if (p == 8'(i)) lvl_bit[NLVL-1-i] = 1'b1;
  endfunction

  function automatic logic [7:0] lead_zero(input logic [NLVL-1:0] b);
    lead_zero = NONE;
    for (int i = NLVL-1; i >= 0; i--)
      if (b[NLVL-1-i]) lead_zero = 8'(i);
  endfunction

  assign pipr     = lead_zero(pbuf);
  assign take     = ack & exc;
  assign cppr_a   = take ? pipr : cppr;
  assign pbuf_a   = take ? (pbuf & ~lvl_bit(pipr)) : pbuf;
  assign cppr_n   = cur_wr ? cur_wdata : cppr_a;
  assign pbuf_n   = pbuf_a | (ntf_valid ? lvl_bit(ntf_prio) : '0)
                           | (pend_wr ? lvl_bit(pend_wdata) : '0);
  assign pipr_n   = lead_zero(pbuf_n);
  assign event_in = ntf_valid | pend_wr | cur_wr;
  assign exc_n    = (exc & ~ack) | (event_in & (pipr_n < cppr_n));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pbuf <= '0;
      cppr <= 8'h00;
      exc  <= 1'b0;
    end else begin
      pbuf <= pbuf_n;
      cppr <= cppr_n;
      exc  <= exc_n;
    end
  end

  assign ack_resp  = ack ? {exc, 7'b0, cppr_a} : 16'h0000;
  assign irq_out   = exc;
  assign cur_prio  = cppr;
  assign pend_prio = pipr;
endmodule

module irq_prio_ctx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ntf_valid,
  input logic        cur_wr,
  input logic        pend_wr,
  input logic        ack,
  input logic [15:0] ack_resp,
  input logic        irq_out,
  input logic [7:0]  cur_prio,
  input logic [7:0]  pend_prio
);
  logic quiet;
  assign quiet = !(ntf_valid || pend_wr || cur_wr);

  assert_pend_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_prio <= 8'd7) || (pend_prio == 8'hFF));

  assert_rise_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && quiet) |=> !irq_out);

  assert_rise_favoured_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !irq_out) |=> (!irq_out || (pend_prio < cur_prio)));

  assert_ack_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && quiet) |=> !irq_out);

  assert_resp_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cur_wr) |=> cur_prio == $past(ack_resp[7:0]));

  assert_resp_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ack_resp[15] == irq_out));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !ack) |=> ($stable(cur_prio) && $stable(pend_prio) && $stable(irq_out)));
endmodule

bind irq_prio_ctx irq_prio_ctx_chk u_chk (.*);

// File: tb/sim_irq_prio_ctx.sv
`timescale 1ns/1ps
module sim_irq_prio_ctx;
  logic        clk = 0, rst_n = 0;
  logic        ntf_valid = 0, cur_wr = 0, pend_wr = 0, ack = 0;
  logic [7:0]  ntf_prio = 0, cur_wdata = 0, pend_wdata = 0;
  logic [15:0] ack_resp;
  logic        irq_out;
  logic [7:0]  cur_prio, pend_prio;

  int checks = 0, errors = 0;
  int m_buf = 0, m_cur = 0, m_exc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_ctx u0 (.*);

  function automatic int bitof(int p);
    return (p > 7) ? 0 : (1 << (7 - p));
  endfunction

  function automatic int lowest(int b);
    int i = 0;
    if (b == 0) return 255;
    while (((b >> (7 - i)) & 1) == 0) i++;
    return i;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(string req);
    chk({req, " cur_prio"}, cur_prio, m_cur);
    chk({req, " pend_prio"}, pend_prio, lowest(m_buf));
    chk({req, " irq_out"}, irq_out, m_exc);
  endtask

  task automatic step(string req, bit n, int np, bit cw, int cd, bit pw, int pd, bit a);
    int rcur;
    ntf_valid = n; ntf_prio = 8'(np); cur_wr = cw; cur_wdata = 8'(cd);
    pend_wr = pw; pend_wdata = 8'(pd); ack = a;
    #1;
    rcur = m_exc ? lowest(m_buf) : m_cur;
    if (a) chk({req, " R8 ack_resp"}, ack_resp, ((m_exc ? 8'h80 : 0) << 8) | rcur);
    else   chk({req, " R8 resp idle"}, ack_resp, 0);
    @(posedge clk);
    if (a && m_exc) begin
      m_cur = lowest(m_buf);
      m_buf = m_buf & ~bitof(m_cur);
      m_exc = 0;
    end else if (a) m_exc = 0;
    if (cw) m_cur = cd;
    if (n) m_buf = m_buf | bitof(np);
    if (pw) m_buf = m_buf | bitof(pd);
    if ((n || pw || cw) && lowest(m_buf) < m_cur) m_exc = 1;
    #1;
    check_state(req);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0;
    check_state("R1 reset");
    step("R1 idle", 0,0, 0,0, 0,0, 0);
    step("R2 notify 5 masked", 1,5, 0,0, 0,0, 0);
    step("R3 notify 9 ignored", 1,9, 0,0, 0,0, 0);
    step("R3 setpend 200 ignored", 0,0, 0,0, 1,200, 0);
    step("R4 R6 cur write 7", 0,0, 1,7, 0,0, 0);
    step("R7 ack", 0,0, 0,0, 0,0, 1);
    step("R9 ack no exc", 0,0, 0,0, 0,0, 1);
    step("R5 equal prio", 1,5, 0,0, 0,0, 0);
    step("R4 notify 3", 1,3, 0,0, 0,0, 0);
    step("R10 setpend 1 and notify 6", 1,6, 0,0, 1,1, 0);
    step("R7 ack 1", 0,0, 0,0, 0,0, 1);
    step("R6 cur write ff", 0,0, 1,255, 0,0, 0);
    step("R11 ack plus notify 0", 1,0, 0,0, 0,0, 1);
    step("R12 ack plus cur write", 0,0, 1,4, 0,0, 1);
    step("R5 cur write 0", 0,0, 1,0, 0,0, 0);
    step("R9 ack masked", 0,0, 0,0, 0,0, 1);
    for (int k = 0; k < 2000; k++) begin
      int cd = ($urandom % 16 == 0) ? 255 : int'($urandom % 9);
      step("R2 R4 R7 R10 R11 random",
           ($urandom % 3) == 0, int'($urandom % 10),
           ($urandom % 5) == 0, cd,
           ($urandom % 6) == 0, int'($urandom % 10),
           ($urandom % 4) == 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule